// File: doc/BRIEF.md
# Four-Share Masked AND-NOT-XOR Gadget

This block evaluates the nonlinear step x ^= (~y & z) on three operands that are each split into four Boolean shares of `WORD_W` bits. Every share k is held rotated right by its own fixed offset r_k, with r_0 = 0. The true value of an operand is therefore the XOR of all four shares after each share k has been rotated left by r_k. The offsets are elaboration-time parameters.

Output share i is built from input share i of x. To it the block XORs four products, one for each share j of y. Each product first rotates y share j into the frame of share i and then ANDs it with z share i. The products enter in share order 0, 1, 2, 3. The complement is applied to y share 0 alone, so the XOR of the y shares becomes ~y.

The gadget is purely combinational. It has no clock, no state and no handshake, so a parent pipeline decides where any registers go. Refreshing the shares with new randomness is left to the surrounding logic.

Top module: `masked_andnot4_gadget`

## Requirements
- R1: Unmask each output share i by rotating it left by r_i and XOR the four results. This must equal X ^ (~Y & Z), where X, Y and Z are the operands unmasked in the same way.
- R2: Output share i includes the product of y share i and z share i with no rotation applied to y share i.
- R3: Only y share 0 is complemented before its product is formed. With all y shares zero and x zero, every output share i equals z share i. With y share 0 zero, y shares 1 to 3 all ones and every z share all ones, the outputs equal the x shares.
- R4: For j < i, y share j is rotated right by r_i - r_j before it is ANDed with z share i.
- R5: For j > i, y share j is rotated right by (r_i - r_j) mod `WORD_W` before it is ANDed with z share i. This is the same as a left rotation by r_j - r_i.
- R6: When z share i is zero, output share i equals x share i, whatever the y shares hold. Output share i depends on no z share other than share i.
- R7: The outputs follow the inputs with no clock or register in between: a new input set is reflected at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_s0_i | input | WORD_W | x operand, share 0 |
| x_s1_i | input | WORD_W | x operand, share 1 |
| x_s2_i | input | WORD_W | x operand, share 2 |
| x_s3_i | input | WORD_W | x operand, share 3 |
| y_s0_i | input | WORD_W | y operand, share 0 (complemented inside) |
| y_s1_i | input | WORD_W | y operand, share 1 |
| y_s2_i | input | WORD_W | y operand, share 2 |
| y_s3_i | input | WORD_W | y operand, share 3 |
| z_s0_i | input | WORD_W | z operand, share 0 |
| z_s1_i | input | WORD_W | z operand, share 1 |
| z_s2_i | input | WORD_W | z operand, share 2 |
| z_s3_i | input | WORD_W | z operand, share 3 |
| x_s0_o | output | WORD_W | updated x, share 0 |
| x_s1_o | output | WORD_W | updated x, share 1 |
| x_s2_o | output | WORD_W | updated x, share 2 |
| x_s3_o | output | WORD_W | updated x, share 3 |

## Verification
The bench sets a single bit in one y share and gates it through a single all-ones z share. This isolates each off-diagonal product, so a rotation in the wrong direction, or by the wrong difference, moves the bit to a visibly wrong position in that output share. All-zero and all-ones y patterns expose a complement placed on the wrong share, or on more than one share: the outputs would then come out inverted where they should equal z or x. Zeroed z shares catch products that leak into a share they do not belong to. Random masked operands are checked against the unmasked equation, which any misplaced rotation or term breaks.

// File: rtl/masked_andnot_pkg.sv
package masked_andnot_pkg;

  localparam int unsigned NUM_SHARES = 4;

  // Right-rotation distance that moves a value stored in share `src`
  // into the frame of share `dst`, given per-share offsets.
  function automatic int unsigned align_dist(
    input int unsigned dst,
    input int unsigned src,
    input int unsigned off1,
    input int unsigned off2,
    input int unsigned off3,
    input int unsigned width
  );
    int unsigned offs [NUM_SHARES];
    offs[0] = 0;
    offs[1] = off1;
    offs[2] = off2;
    offs[3] = off3;
    return (offs[dst] + width - offs[src]) % width;
  endfunction

endpackage

// File: rtl/share_realign.sv
module share_realign #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DIST   = 0,
  parameter bit          INVERT = 1'b0
) (
  input  logic [WORD_W-1:0] share_i,
  output logic [WORD_W-1:0] share_o
);

  logic [WORD_W-1:0] pre_rot;

  generate
    if (INVERT) begin : g_inv
      assign pre_rot = ~share_i;
    end else begin : g_pass
      assign pre_rot = share_i;
    end

    if (DIST == 0) begin : g_norot
      assign share_o = pre_rot;
    end else begin : g_rot
      assign share_o = {pre_rot[DIST-1:0], pre_rot[WORD_W-1:DIST]};
    end
  endgenerate

  // Rotating the result back left by DIST recovers the (possibly inverted) input.
  always_comb begin
    if (!$isunknown(share_i)) begin
      p_rot_inverse_r4: assert (((share_o << DIST) | (share_o >> ((WORD_W - DIST) % WORD_W))) ==
                                (INVERT ? ~share_i : share_i) || DIST == 0)
        else $error("realign rotation mismatch");
    end
  end

endmodule

// File: rtl/share_product_row.sv
module share_product_row
  import masked_andnot_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ROW_IDX = 0,
  parameter int unsigned OFF_1   = 5,
  parameter int unsigned OFF_2   = 11,
  parameter int unsigned OFF_3   = 23
) (
  input  logic [WORD_W-1:0]                 x_i,
  input  logic [WORD_W-1:0]                 z_i,
  input  logic [NUM_SHARES-1:0][WORD_W-1:0] y_i,
  output logic [WORD_W-1:0]                 x_o
);

  logic [NUM_SHARES-1:0][WORD_W-1:0] y_aligned;
  logic [NUM_SHARES-1:0][WORD_W-1:0] term;
  logic [NUM_SHARES-1:0][WORD_W-1:0] acc;

  generate
    for (genvar j = 0; j < NUM_SHARES; j++) begin : g_term
      localparam int unsigned DIST = align_dist(ROW_IDX, j, OFF_1, OFF_2, OFF_3, WORD_W);

      share_realign #(
        .WORD_W (WORD_W),
        .DIST   (DIST),
        .INVERT (j == 0)
      ) u_align (
        .share_i (y_i[j]),
        .share_o (y_aligned[j])
      );

      assign term[j] = y_aligned[j] & z_i;

      if (j == 0) begin : g_first
        assign acc[j] = x_i ^ term[j];
      end else begin : g_next
        assign acc[j] = acc[j-1] ^ term[j];
      end
    end
  endgenerate

  assign x_o = acc[NUM_SHARES-1];

  // A zero z share leaves its x share untouched.
  always_comb begin
    if (!$isunknown({x_i, z_i, y_i})) begin
      p_zero_gate_r6: assert (z_i != '0 || x_o == x_i)
        else $error("row %0d changed with zero z share", ROW_IDX);
      p_diag_r2: assert (((x_o ^ x_i ^ (y_i[ROW_IDX] & z_i)) & ~z_i) == '0)
        else $error("row %0d touched bits outside z", ROW_IDX);
    end
  end

endmodule

// File: rtl/masked_andnot4_gadget.sv
module masked_andnot4_gadget
  import masked_andnot_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned OFF_1  = 5,
  parameter int unsigned OFF_2  = 11,
  parameter int unsigned OFF_3  = 23
) (
  input  logic [WORD_W-1:0] x_s0_i,
  input  logic [WORD_W-1:0] x_s1_i,
  input  logic [WORD_W-1:0] x_s2_i,
  input  logic [WORD_W-1:0] x_s3_i,
  input  logic [WORD_W-1:0] y_s0_i,
  input  logic [WORD_W-1:0] y_s1_i,
  input  logic [WORD_W-1:0] y_s2_i,
  input  logic [WORD_W-1:0] y_s3_i,
  input  logic [WORD_W-1:0] z_s0_i,
  input  logic [WORD_W-1:0] z_s1_i,
  input  logic [WORD_W-1:0] z_s2_i,
  input  logic [WORD_W-1:0] z_s3_i,
  output logic [WORD_W-1:0] x_s0_o,
  output logic [WORD_W-1:0] x_s1_o,
  output logic [WORD_W-1:0] x_s2_o,
  output logic [WORD_W-1:0] x_s3_o
);

  logic [NUM_SHARES-1:0][WORD_W-1:0] x_in, y_in, z_in, x_out;

  assign x_in = {x_s3_i, x_s2_i, x_s1_i, x_s0_i};
  assign y_in = {y_s3_i, y_s2_i, y_s1_i, y_s0_i};
  assign z_in = {z_s3_i, z_s2_i, z_s1_i, z_s0_i};

  generate
    for (genvar i = 0; i < NUM_SHARES; i++) begin : g_row
      share_product_row #(
        .WORD_W  (WORD_W),
        .ROW_IDX (i),
        .OFF_1   (OFF_1),
        .OFF_2   (OFF_2),
        .OFF_3   (OFF_3)
      ) u_row (
        .x_i (x_in[i]),
        .z_i (z_in[i]),
        .y_i (y_in),
        .x_o (x_out[i])
      );
    end
  endgenerate

  assign x_s0_o = x_out[0];
  assign x_s1_o = x_out[1];
  assign x_s2_o = x_out[2];
  assign x_s3_o = x_out[3];

  // Unmasked-domain check of the whole gadget.
  function automatic logic [WORD_W-1:0] rot_left(input logic [WORD_W-1:0] v, input int unsigned n);
    return (n == 0) ? v : ((v << n) | (v >> (WORD_W - n)));
  endfunction

  function automatic logic [WORD_W-1:0] unmask(input logic [NUM_SHARES-1:0][WORD_W-1:0] s);
    return s[0] ^ rot_left(s[1], OFF_1) ^ rot_left(s[2], OFF_2) ^ rot_left(s[3], OFF_3);
  endfunction

  always_comb begin
    if (!$isunknown({x_in, y_in, z_in})) begin
      p_unmasked_r1: assert (unmask(x_out) == (unmask(x_in) ^ (~unmask(y_in) & unmask(z_in))))
        else $error("unmasked result mismatch");
      p_ones_cancel_r3: assert (!(y_in[0] == '0 && y_in[1] == '1 && y_in[2] == '1 &&
                                  y_in[3] == '1) || x_out == x_in)
        else $error("complement applied to more than share 0");
    end
  end

  initial begin
    p_offsets_r5: assert (OFF_1 < WORD_W && OFF_2 < WORD_W && OFF_3 < WORD_W)
      else $error("share offset out of range");
  end

endmodule

// File: tb/masked_andnot4_gadget_tb.sv
module masked_andnot4_gadget_tb_top;

  localparam int unsigned W = 32;
  localparam int unsigned O1 = 5, O2 = 11, O3 = 23;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] xs [4], ys [4], zs [4];
  logic [W-1:0] xo [4];
  int checks = 0, fails = 0;
  bit done = 0;

  masked_andnot4_gadget #(.WORD_W(W), .OFF_1(O1), .OFF_2(O2), .OFF_3(O3)) dut_i (
    .x_s0_i(xs[0]), .x_s1_i(xs[1]), .x_s2_i(xs[2]), .x_s3_i(xs[3]),
    .y_s0_i(ys[0]), .y_s1_i(ys[1]), .y_s2_i(ys[2]), .y_s3_i(ys[3]),
    .z_s0_i(zs[0]), .z_s1_i(zs[1]), .z_s2_i(zs[2]), .z_s3_i(zs[3]),
    .x_s0_o(xo[0]), .x_s1_o(xo[1]), .x_s2_o(xo[2]), .x_s3_o(xo[3])
  );

  function automatic int unsigned off(input int k);
    case (k) 1: return O1; 2: return O2; 3: return O3; default: return 0; endcase
  endfunction

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int unsigned n);
    return (n % W == 0) ? v : ((v >> (n % W)) | (v << (W - n % W)));
  endfunction

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int unsigned n);
    return rotr(v, (W - n % W) % W);
  endfunction

  // Reference share i from R2-R5: y share 0 complemented, share j moved into frame i.
  function automatic logic [W-1:0] ref_share(input int i);
    logic [W-1:0] acc = xs[i];
    for (int j = 0; j < 4; j++) begin
      logic [W-1:0] yv = (j == 0) ? ~ys[j] : ys[j];
      acc ^= rotr(yv, (off(i) + W - off(j)) % W) & zs[i];
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] unm_x();
    logic [W-1:0] r = '0;
    for (int k = 0; k < 4; k++) r ^= rotl(xs[k], off(k));
    return r;
  endfunction
  function automatic logic [W-1:0] unm_y();
    logic [W-1:0] r = '0;
    for (int k = 0; k < 4; k++) r ^= rotl(ys[k], off(k));
    return r;
  endfunction
  function automatic logic [W-1:0] unm_z();
    logic [W-1:0] r = '0;
    for (int k = 0; k < 4; k++) r ^= rotl(zs[k], off(k));
    return r;
  endfunction
  function automatic logic [W-1:0] unm_out();
    logic [W-1:0] r = '0;
    for (int k = 0; k < 4; k++) r ^= rotl(xo[k], off(k));
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_zero();
    for (int k = 0; k < 4; k++) begin xs[k] = '0; ys[k] = '0; zs[k] = '0; end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin xs[k] = '0; ys[k] = '0; zs[k] = '0; end
    void'($urandom(32'd4242));
    #1;
    // Initial state: all-zero inputs give y share 0 complemented but z zero -> outputs zero (R6)
    for (int k = 0; k < 4; k++) check("R6 idle", xo[k], '0);

    // R3: all y zero, x zero -> output share i equals z share i
    apply_zero();
    for (int k = 0; k < 4; k++) zs[k] = 32'hA5A5_0000 ^ (32'h1111 << k);
    settle();
    for (int k = 0; k < 4; k++) check("R3 zero y", xo[k], zs[k]);

    // R3: y0 zero, others ones, z ones -> outputs equal x
    for (int k = 0; k < 4; k++) begin xs[k] = 32'h0BAD_F00D + k; zs[k] = '1; end
    ys[0] = '0; ys[1] = '1; ys[2] = '1; ys[3] = '1;
    settle();
    for (int k = 0; k < 4; k++) check("R3 cancel", xo[k], xs[k]);

    // R2: diagonal products unrotated
    for (int i = 0; i < 4; i++) begin
      apply_zero();
      ys[0] = '1;
      if (i != 0) ys[i] = 32'h1234_5678;
      else ys[0] = ~32'h1234_5678;
      zs[i] = '1;
      settle();
      check("R2 diagonal", xo[i], 32'h1234_5678);
    end

    // R4 / R5: single bit in share j routed through z share i
    for (int i = 0; i < 4; i++)
      for (int j = 1; j < 4; j++) begin
        if (i == j) continue;
        apply_zero();
        ys[0] = '1;
        ys[j] = 32'h0000_0001 << (i + j);
        zs[i] = '1;
        settle();
        if (j < i) check("R4 forward", xo[i], rotr(ys[j], off(i) - off(j)));
        else check("R5 backward", xo[i], rotl(ys[j], off(j) - off(i)));
      end
    // R4: share 0 (complemented) into later shares
    for (int i = 1; i < 4; i++) begin
      apply_zero();
      ys[0] = ~32'h0000_0080;
      zs[i] = '1;
      settle();
      check("R4 share0 forward", xo[i], rotr(32'h0000_0080, off(i)));
    end
    // fixed-value spot checks of the rotation direction
    apply_zero(); ys[0] = '1; ys[1] = 32'h1; zs[2] = '1; settle();
    check("R4 fixed", xo[2], 32'h0400_0000);
    apply_zero(); ys[0] = '1; ys[3] = 32'h1; zs[1] = '1; settle();
    check("R5 fixed", xo[1], 32'h0004_0000);

    // R6: zero z share leaves x share alone despite random y
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 4; k++) begin xs[k] = $urandom; ys[k] = $urandom; zs[k] = $urandom; end
      zs[n % 4] = '0;
      settle();
      check("R6 zero z", xo[n % 4], xs[n % 4]);
    end

    // R1 / R7: random vectors checked per share and unmasked, sampled within the cycle
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 4; k++) begin xs[k] = $urandom; ys[k] = $urandom; zs[k] = $urandom; end
      if (n % 50 == 0) for (int k = 0; k < 4; k++) ys[k] = (n % 100 == 0) ? '1 : '0;
      #1;
      for (int k = 0; k < 4; k++) check("R7 same cycle", xo[k], ref_share(k));
      check("R1 unmasked", unm_out(), unm_x() ^ (~unm_y() & unm_z()));
      settle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule